// File: doc/BRIEF.md
# Stage-1 Table Base Address Former

This block holds the 64-bit table-base register used by a stage-1 address translation. It combines the stored value with the current translation settings to produce the 52-bit physical address where the first table lookup starts. The settings are the alignment exponent (worked out elsewhere from region size and granule), the output-address-size code, a flag for the 64KB granule, and a flag that says whether 52-bit physical addresses are supported. The block also reports an address-size fault, gives out the address-space identifier held in the register, and passes through the shared-table hint.

The register is written through a 64-bit port with an enable and read back unchanged. The base address, the fault flag, the identifier and the hint are purely combinational functions of the stored value and the mode inputs. A new write therefore shows on every output in the cycle right after the write edge.

When 52-bit mode is selected, the top four base bits are packed into register bits [5:2]. In that mode the alignment cannot go below 64 bytes. Register bits below the alignment point are treated as zero, whatever value they hold.

Top module: `ttb_addr_former`

## Requirements
- R1: After reset the stored register is all zeros. Before any write, `rd_data`, `base_addr`, `size_fault`, `space_id` and `shared_hint` are all zero.
- R2: A clock edge with `wr_en` high stores `wr_data`, and `rd_data` returns it from that edge on. An edge with `wr_en` low leaves `rd_data` unchanged.
- R3: In 48-bit layout, `base_addr[47:L]` equals register bits [47:L], where L = max(x,1). All base bits below L are zero, and `base_addr[51:48]` is 0000. When x is 48 or more, `base_addr` is all zero.
- R4: 52-bit mode is selected only when `oa_size` is 3'b110 and `gran_64k` is 1. Code 3'b110 with `gran_64k` = 0 uses the 48-bit layout, and register bits [5:2] then have no effect on `base_addr`.
- R5: In 52-bit mode, `base_addr[51:48]` equals register bits [5:2]. `base_addr[47:z]` equals register bits [47:z], where z = max(x,6). All base bits below z are zero, so `base_addr[5:0]` is always zero.
- R6: `size_fault` is 1 exactly when all of these hold: `pa52_ok` is 0, `gran_64k` is 1, `oa_size` is 3'b110, and register bits [5:2] are nonzero.
- R7: When `host_ext` is 0, `space_id` is zero. When `host_ext` is 1, `space_id` equals register bits [63:48], except that with parameter `ID8_ONLY` = 1 the top 8 bits of `space_id` read as zero.
- R8: `shared_hint` equals register bit 0. Register bit 0 never reaches `base_addr`, so `base_addr[0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_data | input | 64 | Register write value |
| rd_data | output | 64 | Stored register value |
| align_exp | input | 6 | Alignment exponent x |
| oa_size | input | 3 | Output-address-size code |
| gran_64k | input | 1 | 64KB granule in use |
| pa52_ok | input | 1 | 52-bit physical addresses supported |
| host_ext | input | 1 | Host-extension mode; enables the identifier field |
| base_addr | output | 52 | Physical start address of the first lookup |
| size_fault | output | 1 | Address-size fault |
| space_id | output | 16 | Address-space identifier |
| shared_hint | output | 1 | Shared-table hint (register bit 0) |

## Verification
A register write and a change of translation mode can land in the same cycle. The outputs must then reflect the new stored value under the new mode, with no stale mix of the two. The bench provokes this for every vector: it applies each write together with the mode inputs that go with it, on the same falling edge. It then judges `base_addr`, `size_fault` and `rd_data` against hand-computed values at the next falling edge. The fault and the packed upper nibble also come from the same register bits in the same cycle, so vectors with bits [5:2] set are run both with and without 52-bit support.

// File: rtl/ttbf_pkg.sv
package ttbf_pkg;
   // size code that selects the wide output-address layout
   localparam logic [2:0] OA_CODE_WIDE = 3'b110;
   // minimum alignment exponent in wide mode (64-byte floor)
   localparam int WIDE_FLOOR_EXP = 6;
   // minimum alignment exponent in narrow mode (bit 0 is the hint)
   localparam int NARROW_FLOOR_EXP = 1;
   // register bit positions decoded by neighbours
   localparam int HINT_BIT = 0;
   localparam int UPPER_LSB = 2;
   localparam int ID_LSB = 48;
endpackage

// File: rtl/ttbf_store.sv
module ttbf_store #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
   end

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/ttbf_former.sv
module ttbf_former
   import ttbf_pkg::*;
#(
   parameter int LOW_W = 48,
   parameter int UP_W  = 4,
   parameter int X_W   = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LOW_W-1:0]      reg_low,
   input  logic [X_W-1:0]        align_exp,
   input  logic                  wide,
   input  logic                  pa52_ok,
   output logic [UP_W+LOW_W-1:0] base,
   output logic                  fault
);
   localparam int LB_W = X_W + 1;
   localparam logic [LB_W-1:0] FLOOR_W = LB_W'(WIDE_FLOOR_EXP);
   localparam logic [LB_W-1:0] FLOOR_N = LB_W'(NARROW_FLOOR_EXP);

   logic [LB_W-1:0]  x_ext;
   logic [LB_W-1:0]  low_bound;
   logic [LOW_W-1:0] keep;
   logic [UP_W-1:0]  packed_up;

   assign x_ext     = {1'b0, align_exp};
   assign packed_up = reg_low[UPPER_LSB +: UP_W];

   always_comb begin
      if (wide) low_bound = (x_ext < FLOOR_W) ? FLOOR_W : x_ext;
      else      low_bound = (x_ext < FLOOR_N) ? FLOOR_N : x_ext;
   end

   for (genvar i = 0; i < LOW_W; i++) begin : g_keep
      localparam logic [LB_W-1:0] IDX = LB_W'(i);
      assign keep[i] = (IDX >= low_bound);
   end

   assign base  = {(wide ? packed_up : {UP_W{1'b0}}), reg_low & keep};
   assign fault = wide && !pa52_ok && (|packed_up);

   a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
      wide |-> (base[5:0] == 6'd0));
endmodule

// File: rtl/ttbf_id_sel.sv
module ttbf_id_sel #(
   parameter int ID_W     = 16,
   parameter bit ID8_ONLY = 1'b0
) (
   input  logic [ID_W-1:0] raw_id,
   input  logic            host_ext,
   output logic [ID_W-1:0] id
);
   localparam logic [ID_W-1:0] ID_MASK =
      ID8_ONLY ? {{(ID_W-8){1'b0}}, 8'hFF} : {ID_W{1'b1}};

   assign id = host_ext ? (raw_id & ID_MASK) : '0;
endmodule

// File: rtl/ttb_addr_former.sv
module ttb_addr_former
   import ttbf_pkg::*;
#(
   parameter int REG_W    = 64,
   parameter int OA_W     = 52,
   parameter int ID_W     = 16,
   parameter int X_W      = 6,
   parameter bit ID8_ONLY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic [X_W-1:0]   align_exp,
   input  logic [2:0]       oa_size,
   input  logic             gran_64k,
   input  logic             pa52_ok,
   input  logic             host_ext,
   output logic [OA_W-1:0]  base_addr,
   output logic             size_fault,
   output logic [ID_W-1:0]  space_id,
   output logic             shared_hint
);
   localparam int LOW_W = ID_LSB;
   localparam int UP_W  = OA_W - LOW_W;

   if (REG_W != 64) begin : g_bad_reg
      $error("ttb_addr_former: REG_W must be 64");
   end
   if (UP_W != 4) begin : g_bad_oa
      $error("ttb_addr_former: OA_W must be 52");
   end
   if (ID_W != REG_W - ID_LSB) begin : g_bad_id
      $error("ttb_addr_former: ID_W must fill bits above the base field");
   end
   if (X_W < 6) begin : g_bad_x
      $error("ttb_addr_former: X_W must reach exponent 48");
   end

   logic [REG_W-1:0] stored;
   logic             wide;

   ttbf_store #(.W(REG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(stored)
   );

   assign wide = (oa_size == OA_CODE_WIDE) && gran_64k;

   ttbf_former #(.LOW_W(LOW_W), .UP_W(UP_W), .X_W(X_W)) u_former (
      .clk(clk), .rst_n(rst_n),
      .reg_low(stored[LOW_W-1:0]), .align_exp(align_exp),
      .wide(wide), .pa52_ok(pa52_ok),
      .base(base_addr), .fault(size_fault)
   );

   ttbf_id_sel #(.ID_W(ID_W), .ID8_ONLY(ID8_ONLY)) u_id (
      .raw_id(stored[REG_W-1:ID_LSB]), .host_ext(host_ext), .id(space_id)
   );

   assign rd_data     = stored;
   assign shared_hint = stored[HINT_BIT];

   a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == $past(wr_data)));
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(oa_size == 3'b110 && gran_64k) |-> (base_addr[OA_W-1:LOW_W] == '0));
   a_r6_fault_mode: assert property (@(posedge clk) disable iff (!rst_n)
      size_fault |-> (oa_size == 3'b110 && gran_64k && !pa52_ok));
   a_r7_id_off: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ext |-> (space_id == '0));
   a_r8_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
      base_addr[0] == 1'b0);
endmodule

// File: tb/ttb_addr_former_tb.sv
module ttb_addr_former_tb;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [63:0] r;
      logic [5:0]  x;
      logic [2:0]  sz;
      logic        g;
      logic        pa;
      logic [51:0] eb;
      logic        ef;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{64'h0000_1234_5678_9ABF, 6'd12, 3'b101, 1'b0, 1'b0, 52'h0_1234_5678_9000, 1'b0},
      '{64'h0000_1234_5678_9ABF, 6'd12, 3'b110, 1'b0, 1'b0, 52'h0_1234_5678_9000, 1'b0},
      '{64'h0000_1234_5678_9ABF, 6'd12, 3'b110, 1'b1, 1'b1, 52'hF_1234_5678_9000, 1'b0},
      '{64'h0000_1234_5678_9ABF, 6'd12, 3'b110, 1'b1, 1'b0, 52'hF_1234_5678_9000, 1'b1},
      '{64'h0000_0000_0000_00FF, 6'd3,  3'b110, 1'b1, 1'b1, 52'hF_0000_0000_00C0, 1'b0},
      '{64'h0000_0000_0000_00FF, 6'd3,  3'b000, 1'b1, 1'b0, 52'h0_0000_0000_00F8, 1'b0},
      '{64'h0000_0000_0000_00FF, 6'd0,  3'b000, 1'b0, 1'b0, 52'h0_0000_0000_00FE, 1'b0},
      '{64'h0000_0000_0000_00C3, 6'd3,  3'b110, 1'b1, 1'b0, 52'h0_0000_0000_00C0, 1'b0},
      '{64'h0000_FFFF_FFFF_FFFF, 6'd16, 3'b110, 1'b1, 1'b1, 52'hF_FFFF_FFFF_0000, 1'b0},
      '{64'h0000_FFFF_FFFF_FFFF, 6'd16, 3'b110, 1'b0, 1'b0, 52'h0_FFFF_FFFF_0000, 1'b0},
      '{64'h0000_0000_0000_0004, 6'd6,  3'b110, 1'b1, 1'b0, 52'h1_0000_0000_0000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [5:0]  align_exp = '0;
   logic [2:0]  oa_size = '0;
   logic        gran_64k = 1'b0;
   logic        pa52_ok = 1'b0;
   logic        host_ext = 1'b0;

   logic [63:0] rd_data, rd_data8;
   logic [51:0] base_addr, base_addr8;
   logic        size_fault, size_fault8;
   logic [15:0] space_id, space_id8;
   logic        shared_hint, shared_hint8;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ttb_addr_former u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .align_exp(align_exp), .oa_size(oa_size),
      .gran_64k(gran_64k), .pa52_ok(pa52_ok), .host_ext(host_ext),
      .base_addr(base_addr), .size_fault(size_fault),
      .space_id(space_id), .shared_hint(shared_hint)
   );

   ttb_addr_former #(.ID8_ONLY(1'b1)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data8), .align_exp(align_exp), .oa_size(oa_size),
      .gran_64k(gran_64k), .pa52_ok(pa52_ok), .host_ext(host_ext),
      .base_addr(base_addr8), .size_fault(size_fault8),
      .space_id(space_id8), .shared_hint(shared_hint8)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // drive a write plus mode inputs on one falling edge; outputs valid at the next
   task automatic apply(input logic [63:0] v, input logic [5:0] x, input logic [2:0] sz,
                        input logic g, input logic pa);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v; align_exp = x; oa_size = sz; gran_64k = g; pa52_ok = pa;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      host_ext = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 rd_data", rd_data, 64'd0);
      chk("R1 base", {12'd0, base_addr}, 64'd0);
      chk("R1 fault", {63'd0, size_fault}, 64'd0);
      chk("R1 id", {48'd0, space_id}, 64'd0);
      chk("R1 hint", {63'd0, shared_hint}, 64'd0);

      // table walk: R3 R4 R5 R6 R8
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].r, VECS[i].x, VECS[i].sz, VECS[i].g, VECS[i].pa);
         chk($sformatf("R2 readback v%0d", i), rd_data, VECS[i].r);
         chk($sformatf("R3/R4/R5 base v%0d", i), {12'd0, base_addr}, {12'd0, VECS[i].eb});
         chk($sformatf("R6 fault v%0d", i), {63'd0, size_fault}, {63'd0, VECS[i].ef});
      end

      // R2 no write when enable is low
      @(negedge clk);
      wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
      @(negedge clk);
      #1;
      chk("R2 hold", rd_data, 64'h0000_0000_0000_0004);

      // R3 exponent 48 clears the whole base
      apply(64'h0000_FFFF_FFFF_FFFF, 6'd48, 3'b000, 1'b0, 1'b0);
      chk("R3 x48", {12'd0, base_addr}, 64'd0);

      // R7 identifier and R8 hint
      apply(64'hABCD_0000_0000_0001, 6'd0, 3'b000, 1'b0, 1'b0);
      host_ext = 1'b0;
      #1;
      chk("R7 id off", {48'd0, space_id}, 64'd0);
      host_ext = 1'b1;
      #1;
      chk("R7 id full", {48'd0, space_id}, 64'h0000_0000_0000_ABCD);
      chk("R7 id narrow", {48'd0, space_id8}, 64'h0000_0000_0000_00CD);
      chk("R8 hint", {63'd0, shared_hint}, 64'd1);
      chk("R8 bit0 not in base", {12'd0, base_addr}, 64'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule